// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a processor bus and a small on-chip flash word array while the array is open for reprogramming. The processor drives it with 16-bit bus writes. A write is either a command, of which only the low byte is decoded, or the data word of a program sequence. Reads go through a single data port. Depending on the current output mode, that port returns either the addressed array word or the status byte.

A program sequence has two writes. A `0x40` command comes first. The next write carries the target address and the full 16-bit word. The controller then drops its ready flag for a fixed, parameterised busy period and stores the word, provided the target still holds the erased value. It then spends one cycle comparing the stored word with the requested data. From the moment programming starts, reads return status until a read-array command or a flash reset is given. Two error flags record a failed program and any write that arrived while busy. Both flags hold until they are explicitly cleared.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After `rst_n` is asserted (active low, asynchronous), `ready` is 1, the output mode is array, every array word reads `0xFFFF` (the erased value), and the status byte is `0x80`.
- R2: A command write with low byte `0xFF` selects array mode. Each read then returns the full 16-bit word at `bus_addr`. The mode persists across any number of reads until another valid command is written.
- R3: A command write with low byte `0x70` selects status mode. `bus_rdata` is then `{8'h00, status}`, where status bit 7 is `ready`, bit 5 is the busy-write error, bit 4 is the program error, and every other bit is 0.
- R4: A command write with low byte `0x50` clears status bits 4 and 5 and leaves the output mode unchanged.
- R5: A command write with low byte `0x40` makes the next write a data write. That write supplies the target address on `bus_addr` and the full word on `bus_wdata`. `ready` falls on the clock edge that samples it, and the mode becomes status.
- R6: `ready` stays 0 for exactly `BUSY_CYCLES + 1` clock cycles after the data write: `BUSY_CYCLES` cycles of busy timing followed by one verify cycle. A successfully programmed word can be read back in array mode afterwards.
- R7: During command decode, bits 15..8 of `bus_wdata` have no effect.
- R8: Programming a word that does not hold `0xFFFF` leaves that word unchanged and sets status bit 4 when the operation ends. The busy period still lasts the full length.
- R9: A write that arrives while `ready` is 0 is ignored: it is neither decoded as a command nor taken as data. It sets status bit 5.
- R10: Status bits 4 and 5 stay set through other commands and through flash reset. Only a `0x50` command or `rst_n` clears them.
- R11: A one-cycle `flash_rst` pulse (synchronous, active high) does three things. It abandons a pending program sequence, including one that is busy, without writing the array. It returns the mode to array. It makes `ready` 1 on the following cycle.
- R12: A command write with any low byte other than `0xFF`, `0x70`, `0x50` or `0x40` leaves the output mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array and clears all state |
| flash_rst | input | 1 | Synchronous flash reset: aborts any pending operation and returns to array mode |
| bus_we | input | 1 | Bus write strobe for one clock |
| bus_addr | input | ADDR_W | Word address for reads and program data writes |
| bus_wdata | input | 16 | Write data; only bits 7..0 are decoded as a command |
| bus_rdata | output | 16 | Array word in array mode, or `{8'h00, status}` in status mode |
| ready | output | 1 | 1 when idle, 0 during the busy and verify cycles |

## Verification
The hardest situation to create from the ports is a write that lands inside the busy window while the program itself is failing. Both error flags must then end up set together, and the array word must stay untouched. The bench first programs every word of a small array with arithmetically derived data. This leaves no erased word, so any further program attempt is a guaranteed failure. It then issues one such attempt and places a command write a few cycles into the busy period. Afterwards it checks that `ready` still falls and rises on schedule, that the stray write had no command effect, and that the status byte reads `0xB0`.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] ERASED_WORD = 16'hFFFF;

  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_CLEAR_ERR   = 8'h50;
  localparam logic [7:0] OP_PROGRAM     = 8'h40;

  typedef enum logic {
    MODE_ARRAY  = 1'b0,
    MODE_STATUS = 1'b1
  } out_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_DATA = 2'd1,
    ST_BUSY      = 2'd2,
    ST_VERIFY    = 2'd3
  } ctrl_state_e;

  typedef enum logic [2:0] {
    CK_READ_ARRAY,
    CK_READ_STATUS,
    CK_CLEAR_ERR,
    CK_PROGRAM,
    CK_UNKNOWN
  } cmd_kind_e;

  // Only the low byte of a command write carries the opcode.
  function automatic cmd_kind_e classify_opcode(input logic [7:0] op);
    case (op)
      OP_READ_ARRAY:  return CK_READ_ARRAY;
      OP_READ_STATUS: return CK_READ_STATUS;
      OP_CLEAR_ERR:   return CK_CLEAR_ERR;
      OP_PROGRAM:     return CK_PROGRAM;
      default:        return CK_UNKNOWN;
    endcase
  endfunction

  // Status byte layout: bit7 ready, bit5 busy-write error, bit4 program error.
  function automatic logic [7:0] pack_status(input logic rdy,
                                             input logic busy_err,
                                             input logic prog_err);
    return {rdy, 1'b0, busy_err, prog_err, 4'b0000};
  endfunction

endpackage

// File: rtl/fcc_cmd_decode.sv
module fcc_cmd_decode
  import fcc_pkg::*;
(
  input  logic [7:0] opcode,
  output cmd_kind_e  kind
);

  always_comb kind = classify_opcode(opcode);

endmodule

// File: rtl/fcc_busy_timer.sv
module fcc_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic active,
  output logic expire
);

  localparam int unsigned CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (abort) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= LOAD_VAL;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active = active_q;
  assign expire = active_q && (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= LOAD_VAL)); // R6

  AST_EXPIRE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start && !abort) |=> !active_q); // R6

endmodule

// File: rtl/fcc_word_array.sv
module fcc_word_array
  import fcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [WORD_W-1:0] tgt_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_WORD;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data  = mem_q[rd_addr];
  assign tgt_data = mem_q[tgt_addr];

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (mem_q[wr_addr] == ERASED_WORD)); // R8

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flash_rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              ready
);

  ctrl_state_e       state_q;
  out_mode_e         mode_q;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [WORD_W-1:0] tgt_data_q;
  logic              blank_fail_q;
  logic              err_busy_q;
  logic              err_prog_q;

  cmd_kind_e         kind;
  logic              timer_active;
  logic              timer_expire;
  logic [WORD_W-1:0] arr_rd_data;
  logic [WORD_W-1:0] arr_tgt_data;

  // Named internal events.
  logic cmd_accept;
  logic clr_evt;
  logic unknown_evt;
  logic prog_start;
  logic array_wr;
  logic busy_wr;
  logic prog_fail;
  logic tgt_blank;

  fcc_cmd_decode u_decode (
    .opcode (bus_wdata[7:0]),
    .kind   (kind)
  );

  fcc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (prog_start),
    .abort  (flash_rst),
    .active (timer_active),
    .expire (timer_expire)
  );

  fcc_word_array #(.ADDR_W(ADDR_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (array_wr),
    .wr_addr  (tgt_addr_q),
    .wr_data  (tgt_data_q),
    .rd_addr  (bus_addr),
    .rd_data  (arr_rd_data),
    .tgt_addr (tgt_addr_q),
    .tgt_data (arr_tgt_data)
  );

  assign ready       = (state_q != ST_BUSY) && (state_q != ST_VERIFY);
  assign cmd_accept  = bus_we && !flash_rst && (state_q == ST_IDLE);
  assign clr_evt     = cmd_accept && (kind == CK_CLEAR_ERR);
  assign unknown_evt = cmd_accept && (kind == CK_UNKNOWN);
  assign prog_start  = bus_we && !flash_rst && (state_q == ST_WAIT_DATA);
  assign busy_wr     = bus_we && !flash_rst && !ready;
  assign tgt_blank   = (arr_tgt_data == ERASED_WORD);
  assign array_wr    = (state_q == ST_BUSY) && timer_expire && tgt_blank && !flash_rst;
  assign prog_fail   = (state_q == ST_VERIFY) && !flash_rst &&
                       (blank_fail_q || (arr_tgt_data != tgt_data_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      mode_q       <= MODE_ARRAY;
      tgt_addr_q   <= '0;
      tgt_data_q   <= '0;
      blank_fail_q <= 1'b0;
      err_busy_q   <= 1'b0;
      err_prog_q   <= 1'b0;
    end else if (flash_rst) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_ARRAY;
    end else begin
      if (busy_wr)   err_busy_q <= 1'b1;
      if (prog_fail) err_prog_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (bus_we) begin
            case (kind)
              CK_READ_ARRAY:  mode_q  <= MODE_ARRAY;
              CK_READ_STATUS: mode_q  <= MODE_STATUS;
              CK_CLEAR_ERR: begin
                err_busy_q <= 1'b0;
                err_prog_q <= 1'b0;
              end
              CK_PROGRAM:     state_q <= ST_WAIT_DATA;
              default: ;
            endcase
          end
        end
        ST_WAIT_DATA: begin
          if (bus_we) begin
            tgt_addr_q <= bus_addr;
            tgt_data_q <= bus_wdata;
            mode_q     <= MODE_STATUS;
            state_q    <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (timer_expire) begin
            blank_fail_q <= !tgt_blank;
            state_q      <= ST_VERIFY;
          end
        end
        ST_VERIFY: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_rdata = (mode_q == MODE_ARRAY) ? arr_rd_data
                   : {8'h00, pack_status(ready, err_busy_q, err_prog_q)};

  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(prog_start)); // R5

  AST_AUTO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> (mode_q == MODE_STATUS)); // R5

  AST_BUSY_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    busy_wr |=> err_busy_q); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_prog_q && !clr_evt) |=> err_prog_q); // R10

  AST_FLASH_RST: assert property (@(posedge clk) disable iff (!rst_n)
    flash_rst |=> (ready && mode_q == MODE_ARRAY)); // R11

  AST_UNKNOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    unknown_evt |=> $stable(mode_q)); // R12

  AST_TIMER_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |-> timer_active); // R6

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

  localparam int AW    = 3;
  localparam int BUSY  = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flash_rst = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic          ready;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] model [DEPTH];

  flash_cmd_ctrl #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .flash_rst(flash_rst), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ready(ready)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] pattern(input int a);
    logic [15:0] v;
    v = 16'((a * 16'h2F1B) ^ 16'h5A00 ^ (a << 12));
    if (v == 16'hFFFF) v = 16'h0000;
    return v;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic count_busy(output int low);
    low = 0;
    while (!ready && low < 100) begin
      low++;
      @(negedge clk);
    end
  endtask

  task automatic hard_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int low;
    hard_reset();

    // R1: reset state
    check("R1 ready", {15'd0, ready}, 16'd1);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a[AW-1:0], v);
      check("R1 erased", v, 16'hFFFF);
    end
    wr(0, 16'h0070);
    rd(0, v); check("R1/R3 status after reset", v, 16'h0080);
    wr(0, 16'h00FF);

    // R5/R6/R7: program every word, command high byte varied
    for (int a = 0; a < DEPTH; a++) begin
      wr(0, {8'(8'hA0 + a), 8'h40});
      wr(a[AW-1:0], pattern(a));
      model[a] = pattern(a);
      check("R5 ready fell", {15'd0, ready}, 16'd0);
      count_busy(low);
      check("R6 busy length", 16'(low), 16'(BUSY + 1));
      rd(a[AW-1:0], v); check("R5 auto status mode", v, 16'h0080);
    end
    // R2: read array with junk high byte, mode persists over reads
    wr(0, 16'h5AFF);
    for (int pass = 0; pass < 2; pass++)
      for (int a = 0; a < DEPTH; a++) begin
        rd(a[AW-1:0], v); check("R2/R6 readback", v, model[a]);
      end

    // R8: reprogramming a written word fails
    wr(0, 16'h0040);
    wr(3, 16'h1234);
    count_busy(low);
    check("R8 busy still full", 16'(low), 16'(BUSY + 1));
    rd(3, v); check("R8 status program error", v, 16'h0090);
    wr(0, 16'h00FF);
    rd(3, v); check("R8 word unchanged", v, model[3]);

    // R9: write during busy is ignored and flagged
    wr(0, 16'h0040);
    wr(5, 16'h0F0F);
    @(negedge clk);
    wr(0, 16'h00FF);
    check("R9 still busy", {15'd0, ready}, 16'd0);
    count_busy(low);
    check("R9 timing untouched", 16'(low), 16'(BUSY - 2));
    rd(5, v); check("R9 write ignored, status mode kept", v, 16'h00B0);

    // R12: unknown codes keep mode
    wr(0, 16'h0012);
    rd(0, v); check("R12 status kept", v, 16'h00B0);
    wr(0, 16'h00FF);
    wr(0, 16'h7733);
    rd(6, v); check("R12 array kept", v, model[6]);

    // R10 / R4
    wr(0, 16'hFF70);
    rd(0, v); check("R10 errors sticky", v, 16'h00B0);
    wr(0, 16'h1150);
    rd(0, v); check("R4 clear in status mode", v, 16'h0080);
    wr(0, 16'h00FF);
    wr(0, 16'h0050);
    rd(2, v); check("R4 array mode unchanged", v, model[2]);

    // R11: flash reset during busy
    hard_reset();
    wr(0, 16'h0040);
    wr(1, 16'hBEEF);
    @(negedge clk);
    flash_rst = 1'b1;
    @(negedge clk);
    flash_rst = 1'b0;
    check("R11 ready after abort", {15'd0, ready}, 16'd1);
    rd(1, v); check("R11 array mode, word untouched", v, 16'hFFFF);
    repeat (BUSY + 2) @(negedge clk);
    rd(1, v); check("R11 no late write", v, 16'hFFFF);

    // R11: flash reset while awaiting data; next write decodes as command
    wr(0, 16'h0040);
    flash_rst = 1'b1;
    @(negedge clk);
    flash_rst = 1'b0;
    wr(2, 16'h0070);
    check("R11 no busy after abort", {15'd0, ready}, 16'd1);
    rd(2, v); check("R11 write decoded as command", v, 16'h0080);
    wr(0, 16'h00FF);
    rd(2, v); check("R11 target untouched", v, 16'hFFFF);

    // R10: errors survive flash reset
    wr(0, 16'h0040);
    wr(4, 16'h0001);
    wr(0, 16'h00FF);
    count_busy(low);
    flash_rst = 1'b1;
    @(negedge clk);
    flash_rst = 1'b0;
    wr(0, 16'h0070);
    rd(4, v); check("R10 busy error kept over flash reset", v, 16'h00A0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule